// File: doc/BRIEF.md
# PWM Time-Base Counter with Phase Synchronization

This block is the timing heart of a pulse-width modulator channel. A free-running up-counter climbs from zero to a programmable period value and then returns to zero, so one PWM cycle lasts the period value plus one clock. Later stages compare against the counter value to make their output edges. The same counter also drives a one-clock strobe that marks each return to zero.

Software programs the block through a small register port with one write bus and an independent read address. The period can be double-buffered. In that mode a new value is held in a standby copy and moves into the live period only when the count is at zero, so a cycle already in progress is never cut short. Software can also disable the buffering so that period writes take effect at once.

For multi-channel alignment, a synchronization event can reload the counter with a programmable phase offset. The event comes either from an external pulse or from a software-forced trigger, and it takes effect only while phase loading is enabled.

Top module: `pwm_timebase`

## Requirements
- R1: After synchronous reset the counter, the live period, the standby period and the phase all read zero, and the control register reads zero (buffered period mode, phase loading off).
- R2: With no counter write and no accepted sync, the counter rises by one per clock while it is below the live period. When it is at or above the live period, it becomes zero on the next clock.
- R3: With control bit 0 clear, a write to address 0 updates the standby period, and a read of address 0 returns the standby period. The live period takes the standby value at each clock edge where the counter is zero.
- R4: With control bit 0 set, a write to address 0 updates the live period immediately, and a read of address 0 returns the live period. No standby transfer occurs.
- R5: With control bit 1 set, a sync event loads the counter with the phase register (address 1) on the next clock. A sync event is `sync_in` high at a clock edge, or a write to address 3 with data bit 2 set.
- R6: With control bit 1 clear, both kinds of sync event leave the counter on its normal count.
- R7: A write to address 2 loads the counter with the written value and overrides any sync or wrap in the same cycle. A sync load overrides a wrap to zero.
- R8: `zero_pulse` is high in exactly those cycles where `cnt_out` is zero.
- R9: Address 2 reads the counter. Address 3 reads bit 0 (buffering off) and bit 1 (phase enable), and the force bit 2 always reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Write address: 0 period, 1 phase, 2 counter, 3 control |
| reg_wdata | input | 16 | Write data |
| reg_raddr | input | 2 | Read address, same map as writes |
| reg_rdata | output | 16 | Read data for `reg_raddr` |
| sync_in | input | 1 | External synchronization pulse |
| cnt_out | output | 16 | Current counter value |
| zero_pulse | output | 1 | High while the counter is zero |

## Verification
Directed runs first exercise a period change in buffered mode. These runs separate a transfer that waits for the zero count from one that happens at once. The same period change is then repeated in direct mode. Sync pulses are applied with phase loading off and then on, which shows whether the enable gates both the external and the forced trigger. Collisions of a counter write, a sync and a wrap in the same cycle settle the priority order. A long seeded random run then mixes sparse writes to every address, mode flips, phase values above the period and frequent sync pulses. This covers the cases where a shrinking period or a large phase leaves the count above the limit.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

    typedef enum logic [1:0] {
        RA_PERIOD = 2'd0,
        RA_PHASE  = 2'd1,
        RA_COUNT  = 2'd2,
        RA_CTRL   = 2'd3
    } reg_addr_e;

    // Control register bit positions
    localparam int CB_BUF_OFF = 0;
    localparam int CB_PH_EN   = 1;
    localparam int CB_FORCE   = 2;

    typedef struct packed {
        logic phase_en;
        logic buf_off;
    } ctrl_t;

    // Counter update selection, highest priority first
    typedef enum logic [1:0] {
        NX_WRITE,
        NX_PHASE,
        NX_WRAP,
        NX_INC
    } cnt_sel_e;

    function automatic cnt_sel_e pick_next(input logic wr, input logic sync_ld,
                                            input logic at_limit);
        if (wr)            return NX_WRITE;
        else if (sync_ld)  return NX_PHASE;
        else if (at_limit) return NX_WRAP;
        else               return NX_INC;
    endfunction

endpackage

// File: rtl/tbase_regs.sv
module tbase_regs
    import tbase_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  reg_addr_e    addr,
    input  logic [W-1:0] wdata,
    input  logic         at_zero,
    output logic [W-1:0] act_prd,
    output logic [W-1:0] shd_prd,
    output logic [W-1:0] phase,
    output ctrl_t        ctrl,
    output logic         force_sync
);

    logic wr_prd, wr_phs, wr_ctl;

    assign wr_prd     = we && (addr == RA_PERIOD);
    assign wr_phs     = we && (addr == RA_PHASE);
    assign wr_ctl     = we && (addr == RA_CTRL);
    assign force_sync = wr_ctl && wdata[CB_FORCE];

    always_ff @(posedge clk) begin
        if (rst) begin
            act_prd <= '0;
            shd_prd <= '0;
            phase   <= '0;
            ctrl    <= '0;
        end else begin
            if (wr_phs)
                phase <= wdata;
            if (wr_ctl) begin
                ctrl.buf_off  <= wdata[CB_BUF_OFF];
                ctrl.phase_en <= wdata[CB_PH_EN];
            end
            if (ctrl.buf_off) begin
                if (wr_prd)
                    act_prd <= wdata;
            end else begin
                if (wr_prd)
                    shd_prd <= wdata;
                if (at_zero)
                    act_prd <= shd_prd;
            end
        end
    end

endmodule

// File: rtl/tbase_counter.sv
module tbase_counter
    import tbase_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         sync_ld,
    input  logic [W-1:0] phase,
    input  logic [W-1:0] limit,
    output logic [W-1:0] cnt
);

    localparam logic [W-1:0] ONE = W'(1);

    cnt_sel_e     sel;
    logic [W-1:0] nxt;

    always_comb begin
        sel = pick_next(wr, sync_ld, cnt >= limit);
        unique case (sel)
            NX_WRITE: nxt = wdata;
            NX_PHASE: nxt = phase;
            NX_WRAP:  nxt = '0;
            default:  nxt = cnt + ONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= nxt;
    end

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import tbase_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         reg_we,
    input  logic [1:0]   reg_addr,
    input  logic [W-1:0] reg_wdata,
    input  logic [1:0]   reg_raddr,
    output logic [W-1:0] reg_rdata,
    input  logic         sync_in,
    output logic [W-1:0] cnt_out,
    output logic         zero_pulse
);

    logic [W-1:0] act_prd, shd_prd, phase_val;
    ctrl_t        ctrl_q;
    logic         force_sync, sync_evt, cnt_wr, at_zero;
    logic         phase_en_w, buf_off_w;
    reg_addr_e    waddr, raddr;

    assign waddr      = reg_addr_e'(reg_addr);
    assign raddr      = reg_addr_e'(reg_raddr);
    assign phase_en_w = ctrl_q.phase_en;
    assign buf_off_w  = ctrl_q.buf_off;
    assign at_zero    = (cnt_out == '0);
    assign zero_pulse = at_zero;
    assign cnt_wr     = reg_we && (waddr == RA_COUNT);
    assign sync_evt   = phase_en_w && (sync_in || force_sync);

    tbase_regs #(.W(W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .we         (reg_we),
        .addr       (waddr),
        .wdata      (reg_wdata),
        .at_zero    (at_zero),
        .act_prd    (act_prd),
        .shd_prd    (shd_prd),
        .phase      (phase_val),
        .ctrl       (ctrl_q),
        .force_sync (force_sync)
    );

    tbase_counter #(.W(W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .wr      (cnt_wr),
        .wdata   (reg_wdata),
        .sync_ld (sync_evt),
        .phase   (phase_val),
        .limit   (act_prd),
        .cnt     (cnt_out)
    );

    always_comb begin
        unique case (raddr)
            RA_PERIOD: reg_rdata = buf_off_w ? act_prd : shd_prd;
            RA_PHASE:  reg_rdata = phase_val;
            RA_COUNT:  reg_rdata = cnt_out;
            default: begin
                reg_rdata             = '0;
                reg_rdata[CB_BUF_OFF] = buf_off_w;
                reg_rdata[CB_PH_EN]   = phase_en_w;
            end
        endcase
    end

endmodule

// File: rtl/tbase_checker.sv
module tbase_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         reg_we,
    input logic [1:0]   reg_addr,
    input logic [W-1:0] reg_wdata,
    input logic         sync_in,
    input logic [W-1:0] cnt_out,
    input logic [W-1:0] act_prd,
    input logic [W-1:0] shd_prd,
    input logic [W-1:0] phase_val,
    input logic         phase_en_w,
    input logic         buf_off_w
);

    // R2: plain increment below the limit
    a_r2_increment: assert property (@(posedge clk) disable iff (rst)
        (!reg_we && !sync_in && cnt_out < act_prd)
        |=> cnt_out == W'($past(cnt_out) + W'(1)));

    // R2: wrap at or above the limit
    a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
        (!reg_we && !sync_in && cnt_out >= act_prd) |=> cnt_out == '0);

    // R3: standby copied into live period at zero count
    a_r3_transfer: assert property (@(posedge clk) disable iff (rst)
        (!buf_off_w && cnt_out == '0) |=> act_prd == $past(shd_prd));

    // R5: external sync loads phase
    a_r5_sync_load: assert property (@(posedge clk) disable iff (rst)
        (phase_en_w && sync_in && !(reg_we && reg_addr == 2'd2))
        |=> cnt_out == $past(phase_val));

    // R7: counter write wins over everything
    a_r7_write_wins: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == 2'd2) |=> cnt_out == $past(reg_wdata));

endmodule

bind pwm_timebase tbase_checker #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .sync_in    (sync_in),
    .cnt_out    (cnt_out),
    .act_prd    (act_prd),
    .shd_prd    (shd_prd),
    .phase_val  (phase_val),
    .phase_en_w (phase_en_w),
    .buf_off_w  (buf_off_w)
);

// File: tb/pwm_timebase_test.sv
`timescale 1ns/1ps
module pwm_timebase_test;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         reg_we = 1'b0;
    logic [1:0]   reg_addr = 2'd0;
    logic [W-1:0] reg_wdata = '0;
    logic [1:0]   reg_raddr = 2'd0;
    logic [W-1:0] reg_rdata;
    logic         sync_in = 1'b0;
    logic [W-1:0] cnt_out;
    logic         zero_pulse;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    pwm_timebase #(.W(W)) uut (
        .clk        (clk),
        .rst        (rst),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_raddr  (reg_raddr),
        .reg_rdata  (reg_rdata),
        .sync_in    (sync_in),
        .cnt_out    (cnt_out),
        .zero_pulse (zero_pulse)
    );

    // Reference state, built from the requirements
    logic [W-1:0] m_cnt, m_act, m_shd, m_phs;
    logic         m_buf_off, m_ph_en;

    function automatic logic [W-1:0] m_read(input logic [1:0] a);
        case (a)
            2'd0:    return m_buf_off ? m_act : m_shd;
            2'd1:    return m_phs;
            2'd2:    return m_cnt;
            default: return W'({m_ph_en, m_buf_off});
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt <= '0; m_act <= '0; m_shd <= '0; m_phs <= '0;
            m_buf_off <= 1'b0; m_ph_en <= 1'b0;
        end else begin
            logic frc, sy;
            frc = reg_we && reg_addr == 2'd3 && reg_wdata[2];
            sy  = m_ph_en && (sync_in || frc);
            if (reg_we && reg_addr == 2'd2) m_cnt <= reg_wdata;
            else if (sy)                    m_cnt <= m_phs;
            else if (m_cnt >= m_act)        m_cnt <= '0;
            else                            m_cnt <= m_cnt + 1'b1;
            if (m_buf_off) begin
                if (reg_we && reg_addr == 2'd0) m_act <= reg_wdata;
            end else begin
                if (reg_we && reg_addr == 2'd0) m_shd <= reg_wdata;
                if (m_cnt == '0)                m_act <= m_shd;
            end
            if (reg_we && reg_addr == 2'd1) m_phs <= reg_wdata;
            if (reg_we && reg_addr == 2'd3) begin
                m_buf_off <= reg_wdata[0];
                m_ph_en   <= reg_wdata[1];
            end
        end
    end

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare all outputs against the reference (called away from the edge)
    task automatic compare_all(input string tag);
        check({tag, " counter"}, cnt_out, m_cnt);
        check("R8 zero strobe", W'(zero_pulse), W'(m_cnt == '0));
        check({tag, " readback"}, reg_rdata, m_read(reg_raddr));
    endtask

    // Apply one cycle of stimulus at a falling edge, then compare at the next one
    task automatic step(input logic we, input logic [1:0] a, input logic [W-1:0] d,
                        input logic sy, input logic [1:0] ra, input string tag);
        reg_we = we; reg_addr = a; reg_wdata = d; sync_in = sy; reg_raddr = ra;
        @(negedge clk);
        reg_we = 1'b0; sync_in = 1'b0;
        compare_all(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 2'd0, '0, 1'b0, 2'd2, tag);
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset values through the read port
        for (int a = 0; a < 4; a++) begin
            reg_raddr = 2'(a);
            #1;
            check("R1 reset readback", reg_rdata, '0);
        end
        check("R1 reset counter", cnt_out, '0);
        check("R8 reset strobe", W'(zero_pulse), W'(1));

        // R3: buffered period change waits for the zero count
        step(1'b1, 2'd0, 16'd3, 1'b0, 2'd0, "R3 standby write");
        check("R3 standby readback", reg_rdata, 16'd3);
        idle(8, "R3 R2 deferred period");
        check("R3 live period in use", cnt_out, 16'd3);

        // R4: direct period change
        step(1'b1, 2'd3, 16'd1, 1'b0, 2'd3, "R4 direct mode");
        step(1'b1, 2'd0, 16'd6, 1'b0, 2'd0, "R4 direct write");
        check("R4 live readback", reg_rdata, 16'd6);
        idle(9, "R4 R2 direct period");

        // R6: sync ignored with phase loading off
        step(1'b1, 2'd1, 16'd5, 1'b0, 2'd1, "R6 phase write");
        step(1'b1, 2'd2, 16'd1, 1'b0, 2'd2, "R7 counter write");
        step(1'b0, 2'd0, '0, 1'b1, 2'd2, "R6 sync ignored");
        check("R6 counter continues", cnt_out, 16'd2);
        step(1'b1, 2'd3, 16'd5, 1'b0, 2'd3, "R6 forced sync ignored");
        check("R6 forced ignored", cnt_out, 16'd3);
        check("R9 force bit reads zero", reg_rdata, 16'd1);

        // R5: sync with phase loading on
        step(1'b1, 2'd3, 16'd3, 1'b0, 2'd3, "R5 enable");
        step(1'b0, 2'd0, '0, 1'b1, 2'd2, "R5 external sync");
        check("R5 phase loaded", cnt_out, 16'd5);
        step(1'b1, 2'd2, 16'd0, 1'b0, 2'd2, "R7 counter write");
        step(1'b1, 2'd3, 16'd7, 1'b0, 2'd2, "R5 forced sync");
        check("R5 forced phase loaded", cnt_out, 16'd5);

        // R7: priority collisions
        step(1'b1, 2'd2, 16'd9, 1'b1, 2'd2, "R7 write beats sync");
        check("R7 write value", cnt_out, 16'd9);
        step(1'b1, 2'd2, 16'd6, 1'b0, 2'd2, "R7 counter write");
        step(1'b0, 2'd0, '0, 1'b1, 2'd2, "R7 sync beats wrap");
        check("R7 sync at limit", cnt_out, 16'd5);

        // Random mixture
        for (int i = 0; i < 6000; i++) begin
            logic we_r, sy_r;
            logic [1:0] a_r;
            logic [W-1:0] d_r;
            we_r = ($urandom % 8) == 0;
            sy_r = ($urandom % 6) == 0;
            a_r  = 2'($urandom % 4);
            case (a_r)
                2'd3:    d_r = W'($urandom % 8);
                2'd2:    d_r = W'($urandom % 24);
                default: d_r = W'($urandom % 20);
            endcase
            if (($urandom % 200) == 0) begin
                rst = 1'b1;
                @(negedge clk);
                rst = 1'b0;
                compare_all("R1 random reset");
            end
            step(we_r, a_r, d_r, sy_r, 2'($urandom % 4), "R2 R3 R4 R5 R6 R7 R9 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule